// File: doc/BRIEF.md
# Gated-Adder Four-Bit ALU with Status Flags

This block is a purely combinational arithmetic and logic unit for narrow operands. It takes two operands and a three-bit function select, and returns a result together with zero, carry, overflow and negative status bits. A single ripple-carry adder produces every function. Gating logic in front of each adder bit shapes what that bit sees on its two inputs. The lowest select bit also serves as the adder carry-in, so each arithmetic code comes in two forms: plain and plus-one.

The two bitwise functions come from the same adder. The select logic forces every internal carry term to zero, so each sum bit depends only on its own two gated inputs. AND is formed by gating A with B and leaving the second adder input at zero. OR is formed by gating A with the complement of B and placing B on the second input. With all carries killed, those two terms can never both be one.

The operand width is a parameter with a default of four. The select codes and the flag rules are the same at any width.

Top module: `alu_flags4`

## Requirements
- R1: Select 3'b000 drives `result` equal to `opA`, with `flagCarry` and `flagOverflow` both 0.
- R2: Select 3'b001 drives `result` equal to `opA + 1` modulo 16. For example, `opA = 4'hF` gives 0 with carry set.
- R3: Select 3'b010 and 3'b011 both drive `result` equal to `opA & opB`.
- R4: Select 3'b100 drives `result` equal to `opA + opB` modulo 16.
- R5: Select 3'b101 drives `result` equal to `opA + opB + 1` modulo 16.
- R6: Select 3'b110 and 3'b111 both drive `result` equal to `opA | opB`.
- R7: `flagZero` is 1 exactly when all result bits are 0. `flagNeg` always equals result bit 3.
- R8: For selects with bit 1 clear, `flagCarry` is the carry out of the top adder bit. For selects with bit 1 set, `flagCarry` is 0.
- R9: For selects with bit 1 clear, `flagOverflow` is the carry into bit 3 XOR the carry out of bit 3. For selects with bit 1 set, `flagOverflow` is 0.
- R10: When select bit 1 is set, select bit 0 has no effect on `result` or on any of the four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4 | First operand |
| opB | input | 4 | Second operand |
| sel | input | 3 | Function select; bit 0 doubles as the adder carry-in |
| result | output | 4 | Function result |
| flagZero | output | 1 | Result is all zeros |
| flagCarry | output | 1 | Carry out of the top bit (arithmetic only) |
| flagOverflow | output | 1 | Signed overflow (arithmetic only) |
| flagNeg | output | 1 | Copy of the result's top bit |

## Verification
Increment of 4'hF and add-with-carry of 4'hF and 4'hF are targeted. A broken carry chain or a carry-in that does not reach bit 0 shows up there as a wrong wrap or a missing carry flag. Signed-boundary operands such as 4'h7 plus one catch an overflow flag taken from the wrong carry pair. Both logic codes are driven with operands that would produce internal carries. If the kill path were missing, those carries would leak into higher result bits or set carry and overflow during AND and OR, and S0 would start to change the logic results. An exhaustive sweep over all operand and select combinations compares against an independent model.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Strobes sent from the select decoder to the adder datapath
  typedef struct packed {
    logic passA;      // feed A unchanged to adder input X
    logic gateA;      // feed A gated by (optionally inverted) B to X
    logic invertB;    // use ~B in the gating term
    logic passB;      // feed B to adder input Y
    logic killCarry;  // force every internal carry to zero
    logic carryIn;    // adder carry into bit 0
  } alu_strobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0]  sel,
  output alu_strobe_t strobe
);

  logic isLogic;

  always_comb begin
    isLogic          = sel[1];
    strobe.passA     = ~isLogic;
    strobe.gateA     = isLogic;
    strobe.invertB   = isLogic & sel[2];
    strobe.passB     = sel[2];
    strobe.killCarry = isLogic;
    strobe.carryIn   = sel[0] & ~isLogic;
  end

endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
  import alu_pkg::*;
(
  input  logic        aBit,
  input  logic        bBit,
  input  logic        cIn,
  input  alu_strobe_t strobe,
  output logic        sumBit,
  output logic        cOut
);

  logic bTerm;
  logic xIn;
  logic yIn;
  logic genCarry;

  always_comb begin
    bTerm    = strobe.invertB ? ~bBit : bBit;
    if (strobe.passA)      xIn = aBit;
    else if (strobe.gateA) xIn = aBit & bTerm;
    else                   xIn = 1'b0;
    yIn      = strobe.passB & bBit;
    sumBit   = xIn ^ yIn ^ cIn;
    genCarry = (xIn & yIn) | (cIn & (xIn ^ yIn));
    cOut     = strobe.killCarry ? 1'b0 : genCarry;
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  alu_strobe_t      strobe,
  output logic [WIDTH-1:0] result,
  output logic             flagZero,
  output logic             flagCarry,
  output logic             flagOverflow,
  output logic             flagNeg
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH:0] carryVec;

  assign carryVec[0] = strobe.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    alu_bit_cell u_cell (
      .aBit   (opA[i]),
      .bBit   (opB[i]),
      .cIn    (carryVec[i]),
      .strobe (strobe),
      .sumBit (result[i]),
      .cOut   (carryVec[i+1])
    );
  end

  assign flagZero     = ~|result;
  assign flagNeg      = result[TOP];
  assign flagCarry    = carryVec[WIDTH];
  assign flagOverflow = carryVec[WIDTH] ^ carryVec[TOP];

endmodule

// File: rtl/alu_flags4.sv
module alu_flags4
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       sel,
  output logic [WIDTH-1:0] result,
  output logic             flagZero,
  output logic             flagCarry,
  output logic             flagOverflow,
  output logic             flagNeg
);

  alu_strobe_t strobe;

  alu_ctrl u_ctrl (
    .sel    (sel),
    .strobe (strobe)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA          (opA),
    .opB          (opB),
    .strobe       (strobe),
    .result       (result),
    .flagZero     (flagZero),
    .flagCarry    (flagCarry),
    .flagOverflow (flagOverflow),
    .flagNeg      (flagNeg)
  );

endmodule

// File: rtl/alu_flags4_checker.sv
module alu_flags4_checker #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       sel,
  input logic [WIDTH-1:0] result,
  input logic             flagZero,
  input logic             flagCarry,
  input logic             flagOverflow,
  input logic             flagNeg
);

  logic [WIDTH:0] arithSum;
  logic [WIDTH:0] maskedB;

  always_comb begin
    maskedB  = sel[2] ? {1'b0, opB} : '0;
    arithSum = {1'b0, opA} + maskedB + {{WIDTH{1'b0}}, sel[0]};
    if (!sel[1]) begin
      AST_ARITH_SUM: assert ({flagCarry, result} == arithSum); // R8
    end
    if (sel[2:1] == 2'b01) begin
      AST_AND_RESULT: assert (result == (opA & opB)); // R3
    end
    if (sel[2:1] == 2'b11) begin
      AST_OR_RESULT: assert (result == (opA | opB)); // R6
    end
    if (sel[1]) begin
      AST_LOGIC_NO_CARRY: assert (!flagCarry && !flagOverflow); // R9
    end
    AST_ZERO_FLAG: assert (flagZero == (result == '0)); // R7
    AST_NEG_FLAG: assert (flagNeg == result[WIDTH-1]); // R7
  end

endmodule

bind alu_flags4 alu_flags4_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu_flags4_bench.sv
module alu_flags4_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opA = 4'h0;
  logic [3:0] opB = 4'h0;
  logic [2:0] sel = 3'b000;
  logic [3:0] result;
  logic       flagZero;
  logic       flagCarry;
  logic       flagOverflow;
  logic       flagNeg;

  int checkCount = 0;
  int failCount  = 0;
  int cycleCount = 0;
  bit finished   = 1'b0;

  always #5 clk = ~clk;

  alu_flags4 u_alu_flags4 (
    .opA          (opA),
    .opB          (opB),
    .sel          (sel),
    .result       (result),
    .flagZero     (flagZero),
    .flagCarry    (flagCarry),
    .flagOverflow (flagOverflow),
    .flagNeg      (flagNeg)
  );

  // Independent model: returns {result, Z, C, O, N}
  function automatic logic [7:0] model(input logic [3:0] a, input logic [3:0] b,
                                       input logic [2:0] s);
    logic [3:0] r;
    logic       c;
    logic       o;
    logic [4:0] full;
    logic [3:0] low;
    logic [3:0] y;
    if (s[1]) begin
      r = s[2] ? (a | b) : (a & b);
      c = 1'b0;
      o = 1'b0;
    end else begin
      y    = s[2] ? b : 4'h0;
      full = {1'b0, a} + {1'b0, y} + {4'h0, s[0]};
      low  = {1'b0, a[2:0]} + {1'b0, y[2:0]} + {3'h0, s[0]};
      r    = full[3:0];
      c    = full[4];
      o    = low[3] ^ full[4];
    end
    return {r, (r == 4'h0), c, o, r[3]};
  endfunction

  task automatic checkOne(input logic [3:0] a, input logic [3:0] b,
                          input logic [2:0] s, input string tag);
    logic [7:0] expv;
    logic [7:0] actv;
    @(negedge clk);
    opA = a; opB = b; sel = s;
    #2;
    expv = model(a, b, s);
    actv = {result, flagZero, flagCarry, flagOverflow, flagNeg};
    checkCount++;
    if (actv !== expv) begin
      failCount++;
      $display("FAIL %s a=%h b=%h sel=%b actual={res,Z,C,O,N}=%b expected=%b",
               tag, a, b, s, actv, expv);
    end
  endtask

  task automatic testResetState();
    checkOne(4'h0, 4'h0, 3'b000, "R7 reset-state zero");
  endtask

  task automatic testTransfer();
    checkOne(4'hA, 4'h5, 3'b000, "R1 transfer");
    checkOne(4'h7, 4'hF, 3'b000, "R1 transfer no flags");
  endtask

  task automatic testIncrement();
    checkOne(4'hF, 4'h3, 3'b001, "R2 R8 increment wrap");
    checkOne(4'h7, 4'h0, 3'b001, "R2 R9 increment overflow");
    checkOne(4'h4, 4'h0, 3'b001, "R2 increment");
  endtask

  task automatic testAnd();
    checkOne(4'hF, 4'hF, 3'b010, "R3 and all ones");
    checkOne(4'hC, 4'hA, 3'b011, "R3 and s0 set");
  endtask

  task automatic testAdd();
    checkOne(4'h9, 4'h8, 3'b100, "R4 R8 R9 add carry overflow");
    checkOne(4'h3, 4'h5, 3'b100, "R4 R9 add positive overflow");
  endtask

  task automatic testAddCarry();
    checkOne(4'hF, 4'hF, 3'b101, "R5 R8 add plus one");
    checkOne(4'h2, 4'h3, 3'b101, "R5 add plus one small");
  endtask

  task automatic testOr();
    checkOne(4'hF, 4'hF, 3'b110, "R6 or overlap");
    checkOne(4'h0, 4'h0, 3'b111, "R6 R7 or zero");
  endtask

  task automatic testS0Ignored();
    logic [7:0] first;
    logic [7:0] second;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      opA = 4'hB; opB = 4'h6; sel = {k[0], 2'b10};
      #2;
      first = {result, flagZero, flagCarry, flagOverflow, flagNeg};
      @(negedge clk);
      sel = {k[0], 2'b11};
      #2;
      second = {result, flagZero, flagCarry, flagOverflow, flagNeg};
      checkCount++;
      if (first !== second) begin
        failCount++;
        $display("FAIL R10 s0 changed logic output actual=%b expected=%b", second, first);
      end
    end
  endtask

  task automatic testSweep();
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          checkOne(a[3:0], b[3:0], s[2:0], "R1-sweep all functions");
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > 100000) begin
      failCount++;
      $display("FAIL watchdog actual=hung expected=done");
      finish();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testResetState();
    testTransfer();
    testIncrement();
    testAnd();
    testAdd();
    testAddCarry();
    testOr();
    testS0Ignored();
    testSweep();
    finish();
  end

endmodule